// File: doc/BRIEF.md
# Port Pin with Serial Data-Input Takeover

This block is one bit of a general-purpose parallel port. Three single-bit registers sit behind a small CPU register bus: a data bit, a direction bit and a pulldown-inhibit bit. From these bits the block drives the pad's output enable, the pad's output value and the enable of a weak pulldown. When the direction bit is clear the pin is an input. When it is set the pin drives the stored data bit.

A serial peripheral can take over the pin by raising `ser_en`. While `ser_en` is high the driver is off and the pulldown is off. The raw pad level goes straight to `ser_din`, whatever the direction bit holds. The CPU can still write and read the data and direction bits during the takeover, and these accesses do not disturb the serial path. When `ser_en` drops, the stored bits regain control of the pin in the same cycle.

A constant mask-option input can disable the pulldown for good. The pad level seen on the CPU read path first passes through a two-flop synchronizer. The raw reset is asserted asynchronously and released through a two-flop reset synchronizer.

Top module: `gpio_ser_pin`

## Requirements
- R1: While `ser_en` is 1, `pad_oe` is 0 and `ser_din` equals `pad_in` in the same cycle, for either value of the direction bit.
- R2: While `ser_en` is 1, `pd_en` is 0.
- R3: While `ser_en` is 1, CPU writes to the data and direction registers update the stored bits and their read-back, while `pad_oe` stays 0 and `ser_din` keeps following `pad_in`.
- R4: A read at address 0x01 returns the stored data bit when the direction bit is 1. When the direction bit is 0 it returns the pad level sampled two clock edges earlier. The value appears on bit 6 of `rd_data`.
- R5: When `ser_en` falls, `pad_oe`, `pad_out` and `pd_en` follow the stored bits combinationally, with no clock edge in between.
- R6: With `ser_en` 0 and the direction bit 0, `pad_oe` is 0 and `pd_en` is the inverse of the pulldown-inhibit bit (mask option 0).
- R7: With `ser_en` 0 and the direction bit 1, `pad_oe` is 1, `pad_out` equals the data bit and `pd_en` is 0.
- R8: The registers sit at data 0x01, direction 0x05 and pulldown-inhibit 0x11, each on bit 6 of `bus_wdata`. A write takes effect at the clock edge where `bus_wr` is high. Reads of 0x11 and of any unmapped address return 0, and writes to unmapped addresses change nothing.
- R9: After reset the data, direction and pulldown-inhibit bits are 0. So `pad_oe` is 0, `pd_en` is 1 and a read at 0x05 returns 0.
- R10: While `mask_pd_off` is 1, `pd_en` is 0 regardless of the register bits and `ser_en`.
- R11: While `ser_en` is 0, `ser_din` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | CPU register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data, bit 6 used |
| rd_data | output | 8 | Read data for `bus_addr`, bit 6 carries the value |
| ser_en | input | 1 | Serial peripheral takes over the pin |
| mask_pd_off | input | 1 | Static option that disables the pulldown |
| pad_in | input | 1 | Level sensed on the pad |
| pad_oe | output | 1 | Pad driver enable |
| pad_out | output | 1 | Value driven on the pad |
| pd_en | output | 1 | Pulldown device enable |
| ser_din | output | 1 | Serial data input to the peripheral |

## Verification
The properties assume that `mask_pd_off` is static and that `bus_addr` and `bus_wdata` are valid whenever `bus_wr` is high. They also assume `ser_en` changes only between clock edges. The bench drives every input shortly after the falling edge, so all inputs are settled at each rising edge. It changes the mask option only in a short directed phase and keeps it low in the random phase. Random writes are spread over the three mapped addresses and one unmapped address.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  localparam int unsigned GSP_AW      = 8;
  localparam int unsigned GSP_DW      = 8;
  localparam int unsigned GSP_BIT     = 6;
  localparam logic [7:0]  GSP_A_DAT   = 8'h01;
  localparam logic [7:0]  GSP_A_DIR   = 8'h05;
  localparam logic [7:0]  GSP_A_PDI   = 8'h11;

  typedef struct packed {
    logic dat;
    logic dir;
    logic pdi;
  } gsp_cfg_t;
endpackage

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_nxt;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb sr_nxt = {sr_q[STAGES-2:0], d};
    end else begin : g_single
      always_comb sr_nxt = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= sr_nxt;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/gsp_regs.sv
module gsp_regs
  import gsp_pkg::*;
#(
  parameter int unsigned    AW    = GSP_AW,
  parameter int unsigned    DW    = GSP_DW,
  parameter int unsigned    BIT   = GSP_BIT,
  parameter logic [AW-1:0]  A_DAT = AW'(GSP_A_DAT),
  parameter logic [AW-1:0]  A_DIR = AW'(GSP_A_DIR),
  parameter logic [AW-1:0]  A_PDI = AW'(GSP_A_PDI)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output gsp_cfg_t      cfg_q
);
  logic     we_dat, we_dir, we_pdi;
  logic     wbit;
  logic     unused_wbits;
  gsp_cfg_t cfg_nxt;

  assign wbit         = wdata[BIT];
  assign unused_wbits = ^wdata;

  // decoded clock enables, one per field
  always_comb begin
    we_dat = wr && (addr == A_DAT);
    we_dir = wr && (addr == A_DIR);
    we_pdi = wr && (addr == A_PDI);
  end

  always_comb begin
    cfg_nxt = cfg_q;
    if (we_dat) cfg_nxt.dat = wbit;
    if (we_dir) cfg_nxt.dir = wbit;
    if (we_pdi) cfg_nxt.pdi = wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we_dat || we_dir || we_pdi) begin
      cfg_q <= cfg_nxt;
    end
  end
endmodule

// File: rtl/gsp_pinctl.sv
module gsp_pinctl
  import gsp_pkg::*;
#(
  parameter int unsigned    AW    = GSP_AW,
  parameter int unsigned    DW    = GSP_DW,
  parameter int unsigned    BIT   = GSP_BIT,
  parameter logic [AW-1:0]  A_DAT = AW'(GSP_A_DAT),
  parameter logic [AW-1:0]  A_DIR = AW'(GSP_A_DIR)
) (
  input  gsp_cfg_t      cfg,
  input  logic          ser_en,
  input  logic          mask_pd_off,
  input  logic          pad_in,
  input  logic          pad_sync,
  input  logic [AW-1:0] addr,
  output logic          pad_oe,
  output logic          pad_out,
  output logic          pd_en,
  output logic          ser_din,
  output logic [DW-1:0] rd_data
);
  logic cpu_owns;

  // the serial takeover overrides only the pad side, never the registers
  assign cpu_owns = !ser_en;

  always_comb begin
    pad_oe  = cpu_owns && cfg.dir;
    pad_out = cfg.dat;
    pd_en   = cpu_owns && !cfg.dir && !cfg.pdi && !mask_pd_off;
    ser_din = ser_en && pad_in;
  end

  always_comb begin
    rd_data = '0;
    if (addr == A_DAT)      rd_data[BIT] = cfg.dir ? cfg.dat : pad_sync;
    else if (addr == A_DIR) rd_data[BIT] = cfg.dir;
  end
endmodule

// File: rtl/gpio_ser_pin.sv
module gpio_ser_pin
  import gsp_pkg::*;
#(
  parameter int unsigned    AW         = GSP_AW,
  parameter int unsigned    DW         = GSP_DW,
  parameter int unsigned    BIT        = GSP_BIT,
  parameter int unsigned    SYNC_DEPTH = 2,
  parameter logic [AW-1:0]  A_DAT      = AW'(GSP_A_DAT),
  parameter logic [AW-1:0]  A_DIR      = AW'(GSP_A_DIR),
  parameter logic [AW-1:0]  A_PDI      = AW'(GSP_A_PDI)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rd_data,
  input  logic          ser_en,
  input  logic          mask_pd_off,
  input  logic          pad_in,
  output logic          pad_oe,
  output logic          pad_out,
  output logic          pd_en,
  output logic          ser_din
);
  logic     rst_int_n;
  logic     pad_sync;
  gsp_cfg_t cfg_q;

  gsp_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  gsp_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_pad_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pad_in), .q(pad_sync)
  );

  gsp_regs #(
    .AW(AW), .DW(DW), .BIT(BIT), .A_DAT(A_DAT), .A_DIR(A_DIR), .A_PDI(A_PDI)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cfg_q(cfg_q)
  );

  gsp_pinctl #(
    .AW(AW), .DW(DW), .BIT(BIT), .A_DAT(A_DAT), .A_DIR(A_DIR)
  ) u_pinctl (
    .cfg(cfg_q), .ser_en(ser_en), .mask_pd_off(mask_pd_off),
    .pad_in(pad_in), .pad_sync(pad_sync), .addr(bus_addr),
    .pad_oe(pad_oe), .pad_out(pad_out), .pd_en(pd_en),
    .ser_din(ser_din), .rd_data(rd_data)
  );
endmodule

// File: rtl/gsp_checker.sv
module gsp_checker #(
  parameter int unsigned   AW    = 8,
  parameter int unsigned   DW    = 8,
  parameter int unsigned   BIT   = 6,
  parameter logic [AW-1:0] A_DIR = 8'h05
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_en,
  input logic          mask_pd_off,
  input logic          pad_in,
  input logic          pad_oe,
  input logic          pd_en,
  input logic          ser_din,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          dir_q
);
  assert_takeover_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (!pad_oe && (ser_din == pad_in)));

  assert_pd_off_ser_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> !pd_en);

  assert_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en && dir_q) |-> (pad_oe && !pd_en));

  assert_dir_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_DIR)) |=> (dir_q == $past(bus_wdata[BIT])));

  assert_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_pd_off |-> !pd_en);

  assert_sdi_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> !ser_din);
endmodule

bind gpio_ser_pin gsp_checker #(
  .AW(AW), .DW(DW), .BIT(BIT), .A_DIR(A_DIR)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .ser_en(ser_en), .mask_pd_off(mask_pd_off),
  .pad_in(pad_in), .pad_oe(pad_oe), .pd_en(pd_en), .ser_din(ser_din),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .dir_q(cfg_q.dir)
);

// File: tb/gpio_ser_pin_tb.sv
`timescale 1ns/1ps
module gpio_ser_pin_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] rd_data;
  logic       ser_en, mask_pd_off, pad_in;
  logic       pad_oe, pad_out, pd_en, ser_din;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  // reference model state
  bit m_dat, m_dir, m_pdi, m_s1, m_s2;
  int m_rcnt;

  always #2.5 clk = ~clk;

  gpio_ser_pin dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .ser_en(ser_en),
    .mask_pd_off(mask_pd_off), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pd_en(pd_en), .ser_din(ser_din)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dat = 0; m_dir = 0; m_pdi = 0; m_s1 = 0; m_s2 = 0; m_rcnt = 0;
    end else begin
      if (m_rcnt >= 2) begin
        if (bus_wr && bus_addr == 8'h01) m_dat = bus_wdata[6];
        if (bus_wr && bus_addr == 8'h05) m_dir = bus_wdata[6];
        if (bus_wr && bus_addr == 8'h11) m_pdi = bus_wdata[6];
        m_s2 = m_s1;
        m_s1 = pad_in;
      end
      if (m_rcnt < 2) m_rcnt++;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      bit e_pd;
      bit [7:0] e_rd;
      e_pd = !mask_pd_off && !ser_en && !m_dir && !m_pdi;
      e_rd = 8'h00;
      if (bus_addr == 8'h01)      e_rd[6] = m_dir ? m_dat : m_s2;
      else if (bus_addr == 8'h05) e_rd[6] = m_dir;
      chk(ser_en ? "R1" : (m_dir ? "R7" : "R6"), {7'b0, pad_oe}, {7'b0, !ser_en && m_dir});
      chk("R7 pad_out", {7'b0, pad_out}, {7'b0, m_dat});
      chk(ser_en ? "R2" : (mask_pd_off ? "R10" : "R6"), {7'b0, pd_en}, {7'b0, e_pd});
      chk(ser_en ? "R1" : "R11", {7'b0, ser_din}, {7'b0, ser_en && pad_in});
      chk("R4/R8 read", rd_data, e_rd);
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    tick();
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    #0.5;
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 8'h00; bus_wr = 1'b0; bus_wdata = 8'h00;
    ser_en = 1'b0; mask_pd_off = 1'b0; pad_in = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    cmp_on = 1'b1;

    // R9 reset state
    chk("R9 pad_oe", {7'b0, pad_oe}, 8'h00);
    chk("R9 pd_en", {7'b0, pd_en}, 8'h01);
    rd_chk("R9 dir read", 8'h05, 8'h00);

    // R6 pulldown inhibit, R8 inhibit register reads as zero
    wr(8'h11, 8'h40);
    #0.5 chk("R6 inhibit set", {7'b0, pd_en}, 8'h00);
    rd_chk("R8 pdi read zero", 8'h11, 8'h00);
    wr(8'h11, 8'h00);
    #0.5 chk("R6 inhibit clear", {7'b0, pd_en}, 8'h01);

    // R7 output mode
    wr(8'h01, 8'h40);
    wr(8'h05, 8'h40);
    #0.5 chk("R7 oe", {7'b0, pad_oe}, 8'h01);
    chk("R7 out", {7'b0, pad_out}, 8'h01);
    chk("R7 pd off", {7'b0, pd_en}, 8'h00);
    rd_chk("R4 stored data", 8'h01, 8'h40);

    // R4 synchronized pad read
    wr(8'h05, 8'h00);
    tick(); pad_in = 1'b1;
    rd_chk("R4 sync 0 edges", 8'h01, 8'h00);
    tick();
    rd_chk("R4 sync 1 edge", 8'h01, 8'h00);
    tick();
    rd_chk("R4 sync 2 edges", 8'h01, 8'h40);

    // R1 R2 R3 serial takeover with direction set
    wr(8'h05, 8'h40);
    tick(); ser_en = 1'b1; pad_in = 1'b0;
    #0.5 chk("R1 oe off", {7'b0, pad_oe}, 8'h00);
    chk("R1 sdi low", {7'b0, ser_din}, 8'h00);
    chk("R2 pd off", {7'b0, pd_en}, 8'h00);
    pad_in = 1'b1;
    #0.5 chk("R1 sdi high", {7'b0, ser_din}, 8'h01);
    wr(8'h01, 8'h00);
    rd_chk("R3 data write under takeover", 8'h01, 8'h00);
    chk("R3 oe stays off", {7'b0, pad_oe}, 8'h00);
    chk("R3 sdi follows pad", {7'b0, ser_din}, 8'h01);
    wr(8'h01, 8'h40);
    rd_chk("R3 data rewrite", 8'h01, 8'h40);

    // R5 release restores stored control without a clock edge
    tick(); ser_en = 1'b0;
    #0.5 chk("R5 oe back", {7'b0, pad_oe}, 8'h01);
    chk("R5 out back", {7'b0, pad_out}, 8'h01);
    chk("R11 sdi idle", {7'b0, ser_din}, 8'h00);

    // R8 unmapped address ignored
    wr(8'h02, 8'hFF);
    rd_chk("R8 unmapped read", 8'h02, 8'h00);
    rd_chk("R8 dir unchanged", 8'h05, 8'h40);
    rd_chk("R8 data unchanged", 8'h01, 8'h40);

    // R10 mask option
    wr(8'h05, 8'h00);
    tick(); mask_pd_off = 1'b1;
    #0.5 chk("R10 mask", {7'b0, pd_en}, 8'h00);
    tick(); mask_pd_off = 1'b0;
    #0.5 chk("R10 mask off", {7'b0, pd_en}, 8'h01);

    // random phase, model compared on every clock
    for (int i = 0; i < 400; i++) begin
      tick();
      ser_en = ($urandom_range(0, 3) == 0);
      pad_in = $urandom_range(0, 1);
      bus_wr = $urandom_range(0, 1);
      bus_wdata = $urandom_range(0, 1) ? 8'h40 : 8'h00;
      case ($urandom_range(0, 3))
        0: bus_addr = 8'h01;
        1: bus_addr = 8'h05;
        2: bus_addr = 8'h11;
        default: bus_addr = 8'h02;
      endcase
    end
    tick(); bus_wr = 1'b0;
    tick();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule